// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four pulse-width-modulated pins from one system clock. Its time base is a one-cycle enable pulse `e_tick`. A free-running divider advances on that pulse. Two taps on the divider give two slower tick streams. The "A" tick can be slowed by up to eight, and the "B" tick by up to one hundred and twenty-eight. A second external tick, `s_tick`, is an already-scaled time base. Each channel can use `s_tick` in place of its prescaled tick. Channels 1 and 2 pick between the A tick and `s_tick`. Channels 3 and 4 pick between the B tick and `s_tick`.

Each channel has an 8-bit up-counter, a period value, a duty value and a polarity bit. Polarity decides whether a period starts high or starts low. The output flips to the other level once the counter reaches the duty value. Software programs everything through a plain single-cycle write port: `wr_en`, `wr_addr` and `wr_data`. No flow-control handshake is needed, because every write completes in the cycle it is presented. Period and duty writes are staged and only take effect at the channel's next wrap, so a changed setting never produces a runt pulse.

All logic runs in the single `clk` domain. The prescalers are clock enables, not derived clocks.

Top module: `quad_pwm_core`

## Requirements
- R1: After reset, every register reads as zero. With duty 0 and polarity 0 the outputs then sit at their end level, so `pwm_out` is 4'b1111.
- R2: Writing address 0 sets the A-tick select from bits 1:0. Encodings 0, 1, 2 and 3 give one A tick per 1, 2, 4 and 8 `e_tick` pulses.
- R3: Writing address 0 sets the B-tick select from bits 4:2. Encoding n (0 to 7) gives one B tick per 2^n `e_tick` pulses.
- R4: Address 1 is the control byte. Bits 7, 6, 5 and 4 are the source selects for channels 4, 3, 2 and 1. Bits 3 down to 0 are the polarities for channels 4 down to 1. A source-select value of 1 makes the channel count on `s_tick`.
- R5: A source-select value of 0 makes channels 1 and 2 count on the A tick, and channels 3 and 4 count on the B tick.
- R6: With polarity 1, a channel is high from the start of each period until its counter reaches the duty value, and low after that. With polarity 0, the levels are swapped.
- R7: A channel counter advances by one on each tick of its chosen source and holds otherwise. It wraps to 0 on the tick where it equals period-1. A period of 0 acts as 256.
- R8: A duty of 0 keeps the output at its end level for the whole period. A duty at or above a nonzero period keeps it at its start level.
- R9: The periods of channels 1 to 4 are at addresses 2 to 5, and the duties at addresses 6 to 9. A written value is loaded into the channel only on its next wrap. Writes to addresses 10 to 15 change nothing.
- R10: The prescale divider advances only on `e_tick`. Neither the A tick nor the B tick occurs without `e_tick`, and polarity changes apply at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e_tick | input | 1 | One-cycle base time enable |
| s_tick | input | 1 | One-cycle externally scaled time enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | PWM pins, bit 0 is channel 1 |

## Verification
The assertions only assume that `e_tick` and `s_tick` are plain level samples taken on each clock. They assume nothing about how often either tick arrives, and they allow writes on any cycle, even in the same cycle as a wrap. The stimulus uses the same freedom. It runs `e_tick` continuously, then in bursts, then at random. It pulses `s_tick` on a fixed stride and rewrites period and duty in the middle of a period. It changes the prescale select while the divider is running. Every write goes through the normal port, one per cycle, and the stimulus includes writes to unused addresses.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int N_CH    = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] ADR_PRESCALE = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CONTROL  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_PER_BASE = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_DTY_BASE = 4'd6;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pwm_divider.sv
module pwm_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_tick,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (e_tick) div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_tap.sv
module pwm_tap #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 7
) (
  input  logic             e_tick,
  input  logic [DIV_W-1:0] div_q,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] mask;
  always_comb begin
    mask = (DIV_W'(1) << sel) - DIV_W'(1);
    tick = e_tick && ((div_q & mask) == mask);
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import quad_pwm_pkg::*;
#(
  parameter int A_SEL_W = 2,
  parameter int B_SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  byte_t                 wr_data,
  output logic [A_SEL_W-1:0]    sel_a,
  output logic [B_SEL_W-1:0]    sel_b,
  output byte_t                 ctrl,
  output logic [N_CH-1:0][DATA_W-1:0] per_stage,
  output logic [N_CH-1:0][DATA_W-1:0] dty_stage
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_a <= '0;
      sel_b <= '0;
      ctrl  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_PRESCALE) begin
        sel_a <= wr_data[A_SEL_W-1:0];
        sel_b <= wr_data[A_SEL_W +: B_SEL_W];
      end
      if (wr_addr == ADR_CONTROL) ctrl <= wr_data;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        per_stage[i] <= '0;
        dty_stage[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADR_PER_BASE + ADDR_W'(i)) per_stage[i] <= wr_data;
        if (wr_addr == ADR_DTY_BASE + ADDR_W'(i)) dty_stage[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import quad_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  pol,
  input  byte_t per_stage,
  input  byte_t dty_stage,
  output logic  pwm,
  output byte_t cnt_o,
  output byte_t act_per_o,
  output byte_t act_dty_o
);
  byte_t cnt_q, per_q, dty_q;
  logic  at_end;

  assign at_end = (cnt_q == per_q - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      dty_q <= '0;
    end else if (tick) begin
      if (at_end) begin
        cnt_q <= '0;
        per_q <= per_stage;
        dty_q <= dty_stage;
      end else begin
        cnt_q <= cnt_q + DATA_W'(1);
      end
    end
  end

  always_comb pwm = (cnt_q < dty_q) ? pol : ~pol;

  assign cnt_o     = cnt_q;
  assign act_per_o = per_q;
  assign act_dty_o = dty_q;
endmodule

// File: rtl/quad_pwm_core.sv
module quad_pwm_core
  import quad_pwm_pkg::*;
#(
  parameter int A_SEL_W = 2,
  parameter int B_SEL_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        e_tick,
  input  logic        s_tick,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [3:0]  pwm_out
);
  localparam int DIV_W = (1 << B_SEL_W) - 1;

  logic [DIV_W-1:0]   div_q;
  logic [A_SEL_W-1:0] sel_a;
  logic [B_SEL_W-1:0] sel_b;
  byte_t              ctrl_q;
  logic               tick_a, tick_b;
  logic [N_CH-1:0]    ch_tick;
  logic [N_CH-1:0][DATA_W-1:0] per_stage, dty_stage;
  logic [N_CH-1:0][DATA_W-1:0] cnt_w, aper_w, adty_w;

  pwm_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .e_tick(e_tick), .div_q(div_q)
  );

  pwm_tap #(.SEL_W(A_SEL_W), .DIV_W(DIV_W)) u_tap_a (
    .e_tick(e_tick), .div_q(div_q), .sel(sel_a), .tick(tick_a)
  );

  pwm_tap #(.SEL_W(B_SEL_W), .DIV_W(DIV_W)) u_tap_b (
    .e_tick(e_tick), .div_q(div_q), .sel(sel_b), .tick(tick_b)
  );

  pwm_regs #(.A_SEL_W(A_SEL_W), .B_SEL_W(B_SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_a(sel_a), .sel_b(sel_b), .ctrl(ctrl_q),
    .per_stage(per_stage), .dty_stage(dty_stage)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic src_tick;
    if (i < N_CH / 2) begin : g_src_a
      assign src_tick = tick_a;
    end else begin : g_src_b
      assign src_tick = tick_b;
    end
    assign ch_tick[i] = ctrl_q[N_CH + i] ? s_tick : src_tick;

    pwm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ch_tick[i]), .pol(ctrl_q[i]),
      .per_stage(per_stage[i]), .dty_stage(dty_stage[i]),
      .pwm(pwm_out[i]), .cnt_o(cnt_w[i]), .act_per_o(aper_w[i]),
      .act_dty_o(adty_w[i])
    );
  end
endmodule

// File: rtl/quad_pwm_checker.sv
module quad_pwm_checker (
  input logic             clk,
  input logic             rst_n,
  input logic             e_tick,
  input logic             s_tick,
  input logic             tick_a,
  input logic             tick_b,
  input logic [3:0]       ch_tick,
  input logic [3:0][7:0]  cnt,
  input logic [3:0][7:0]  act_per,
  input logic [3:0][7:0]  act_dty,
  input logic [3:0]       pol,
  input logic [3:0]       pwm_out
);
  a_r10_tick_a_needs_e: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |-> e_tick);
  a_r10_tick_b_needs_e: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |-> e_tick);
  a_r5_tick_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_tick) |-> (e_tick || s_tick));

  for (genvar i = 0; i < 4; i++) begin : g_chk
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_tick[i] |=> $stable(cnt[i]));
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tick[i] && cnt[i] == act_per[i] - 8'd1) |=> cnt[i] == 8'd0);
    a_r9_load_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_tick[i] |=> ($stable(act_per[i]) && $stable(act_dty[i])));
    a_r8_zero_duty_end: assert property (@(posedge clk) disable iff (!rst_n)
      act_dty[i] == 8'd0 |-> pwm_out[i] == ~pol[i]);
    a_r8_full_duty_start: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per[i] != 8'd0 && act_dty[i] >= act_per[i]) |-> pwm_out[i] == pol[i]);
  end
endmodule

bind quad_pwm_core quad_pwm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .e_tick(e_tick), .s_tick(s_tick),
  .tick_a(tick_a), .tick_b(tick_b), .ch_tick(ch_tick), .cnt(cnt_w),
  .act_per(aper_w), .act_dty(adty_w), .pol(ctrl_q[3:0]), .pwm_out(pwm_out)
);

// File: tb/quad_pwm_core_tb_top.sv
module quad_pwm_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       e_tick = 1'b0;
  logic       s_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_out;

  always #10 clk = ~clk;

  quad_pwm_core dut_i (
    .clk(clk), .rst_n(rst_n), .e_tick(e_tick), .s_tick(s_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  int    e_mode = 0;
  int    s_stride = 0;
  int    cyc = 0;

  int m_div, m_sela, m_selb;
  logic [7:0] m_ctrl;
  int m_per[4], m_dty[4], m_cnt[4], m_ap[4], m_ad[4];

  function automatic logic [3:0] model_out();
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = (m_cnt[i] < m_ad[i]) ? m_ctrl[i] : ~m_ctrl[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_sela = 0; m_selb = 0; m_ctrl = '0;
      for (int i = 0; i < 4; i++) begin
        m_per[i] = 0; m_dty[i] = 0; m_cnt[i] = 0; m_ap[i] = 0; m_ad[i] = 0;
      end
    end else begin
      bit ta, tb, t;
      int lim, ma, mb;
      ma = (1 << m_sela) - 1;
      mb = (1 << m_selb) - 1;
      ta = e_tick && ((m_div & ma) == ma);
      tb = e_tick && ((m_div & mb) == mb);
      for (int i = 0; i < 4; i++) begin
        t = m_ctrl[4+i] ? s_tick : ((i < 2) ? ta : tb);
        if (t) begin
          lim = (m_ap[i] == 0) ? 255 : m_ap[i] - 1;
          if (m_cnt[i] == lim) begin
            m_cnt[i] = 0; m_ap[i] = m_per[i]; m_ad[i] = m_dty[i];
          end else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (e_tick) m_div = (m_div + 1) % 128;
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_sela = wr_data[1:0]; m_selb = wr_data[4:2];
        end else if (wr_addr == 1) m_ctrl = wr_data;
        else if (wr_addr >= 2 && wr_addr <= 5) m_per[wr_addr-2] = wr_data;
        else if (wr_addr >= 6 && wr_addr <= 9) m_dty[wr_addr-6] = wr_data;
      end
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: pwm_out actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) check(cur_req, pwm_out, model_out());
    case (e_mode)
      0: e_tick <= 1'b0;
      1: e_tick <= 1'b1;
      2: e_tick <= ((cyc % 16) < 5);
      default: e_tick <= 1'($urandom_range(0, 1));
    endcase
    s_tick <= (s_stride != 0) && ((cyc % s_stride) == 0);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    check("R1", pwm_out, 4'b1111);
    cmp_on = 1'b1;

    cur_req = "R9";
    e_mode = 1;
    wr(4'd2, 8'd10); wr(4'd6, 8'd3);
    wr(4'd3, 8'd7);  wr(4'd7, 8'd0);
    wr(4'd4, 8'd5);  wr(4'd8, 8'd20);
    wr(4'd5, 8'd12); wr(4'd9, 8'd6);
    wr(4'd12, 8'hFF); wr(4'd15, 8'hAA);
    run(270);

    cur_req = "R6"; wr(4'd1, 8'b0000_0101); run(60);
    cur_req = "R7"; wr(4'd1, 8'b0000_1010); run(60);

    cur_req = "R2"; wr(4'd0, 8'b000_000_10); run(120);
    wr(4'd0, 8'b000_000_11); run(150);
    wr(4'd0, 8'b000_000_01); run(80);

    cur_req = "R3"; wr(4'd0, 8'b000_011_00); run(250);
    wr(4'd0, 8'b000_101_00); run(800);
    wr(4'd0, 8'b000_111_00); run(1800);
    wr(4'd0, 8'b000_000_00); run(60);

    cur_req = "R4"; s_stride = 3; wr(4'd1, 8'b1010_0110); run(150);
    cur_req = "R5"; wr(4'd1, 8'b0101_1001); run(150);
    s_stride = 0; wr(4'd1, 8'b0000_1111); run(40);

    cur_req = "R8";
    wr(4'd3, 8'd6); wr(4'd7, 8'd0);
    wr(4'd4, 8'd5); wr(4'd8, 8'd5);
    run(40);

    cur_req = "R9";
    run(3);
    wr(4'd2, 8'd4); wr(4'd6, 8'd2); run(5);
    wr(4'd2, 8'd9); wr(4'd6, 8'd7); run(60);
    wr(4'd13, 8'h00); run(30);

    cur_req = "R10";
    wr(4'd0, 8'b000_010_01);
    e_mode = 0; run(50);
    e_mode = 2; run(400);
    e_mode = 3; run(600);
    wr(4'd1, 8'b0000_0011); run(30);

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule